// File: doc/BRIEF.md
# TLB miss assist register loader

This block keeps the small set of memory-management assist registers that a miss handler works with. It also fills those registers with configured defaults at the moment a translation miss is signalled. Five 32-bit registers are held:

- a defaults register;
- a selection register;
- a tag/size register;
- a page-attribute register;
- a search-control register.

Software reaches all five through a single supervisor-only read/write port. Bit positions below use a big-endian 64-bit numbering: architectural bit 32 is vector bit 31 and architectural bit 63 is vector bit 0.

When `miss` is high at a clock edge, the fields of the defaults register are copied into their target registers. The translation ID is chosen from three process-ID inputs or forced to zero. The search-control register is primed with process ID 0 and the address space of the access that missed, so that a search can follow at once. All updates take effect on the clock edge.

Top module: `tlb_miss_loader`

## Requirements
- R1: After reset, every register reads 0x00000000 and `priv_err` is low.
- R2: A supervisor write (`reg_en`=1, `reg_we`=1, `user_mode`=0) takes effect at the next clock edge. Register indices are: 0 = defaults, 1 = selection, 2 = tag, 3 = attribute, 4 = search. The writable bits of each register are:
  - defaults: 0x30030F7F;
  - selection: 0x30000000;
  - tag: 0x00FF0F00;
  - attribute: 0x0000007F;
  - search: 0xFF000001.
  All other bits read as zero and ignore writes. Indices 5 to 7 read zero and their writes change nothing.
- R3: On a miss, defaults bits [29:28] (table-select default) are copied into selection bits [29:28].
- R4: On a miss, defaults bits [17:16] choose the translation ID written to tag bits [23:16]: 00 selects `pid0`, 01 selects `pid1`, 10 selects `pid2`, and 11 writes 0x00.
- R5: On a miss, defaults bits [11:8] (size default) are copied into tag bits [11:8].
- R6: On a miss, the seven single-bit attribute defaults in defaults bits [6:0] are copied into attribute bits [6:0].
- R7: On a miss, search bits [31:24] are loaded from `pid0` and search bit 0 from `miss_as`.
- R8: Any access with `user_mode`=1 and `reg_en`=1 raises `priv_err` in that cycle, returns 0 on `reg_rdata`, and changes no register.
- R9: If a supervisor write to the selection, tag, attribute or search register coincides with a miss, the miss values are stored. A write to the defaults register in a miss cycle is stored, and the miss uses the defaults held before that edge.
- R10: Without a miss or a supervisor write to it, a register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| user_mode | input | 1 | Access issued from user mode |
| reg_rdata | output | 32 | Read data (combinational) |
| priv_err | output | 1 | Privilege violation flag |
| pid0 | input | 8 | Current process ID 0 |
| pid1 | input | 8 | Current process ID 1 |
| pid2 | input | 8 | Current process ID 2 |
| miss | input | 1 | Translation-miss strobe |
| miss_as | input | 1 | Address space of the missing access |
| dflt_q | output | 32 | Defaults register |
| sel_q | output | 32 | Selection register |
| tag_q | output | 32 | Tag/size register |
| attr_q | output | 32 | Attribute register |
| srch_q | output | 32 | Search-control register |

## Verification
The assertions assume that `miss`, the process IDs and `miss_as` are valid and stable at each clock edge. They also assume that `reg_sel` is meaningful only while `reg_en` is high. The bench changes every input on the falling clock edge and holds it through the next rising edge, so each value seen at an edge was set half a period earlier. It holds `reg_en` low whenever no access is intended, which keeps stray writes from disturbing the hold checks.

// File: rtl/tlb_miss_loader.sv
module tlb_miss_loader #(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic             user_mode,
  output logic [31:0]      reg_rdata,
  output logic             priv_err,
  input  logic [PID_W-1:0] pid0,
  input  logic [PID_W-1:0] pid1,
  input  logic [PID_W-1:0] pid2,
  input  logic             miss,
  input  logic             miss_as,
  output logic [31:0]      dflt_q,
  output logic [31:0]      sel_q,
  output logic [31:0]      tag_q,
  output logic [31:0]      attr_q,
  output logic [31:0]      srch_q
);
  localparam logic [31:0] DFLT_MASK = 32'h3003_0F7F;
  localparam logic [31:0] SEL_MASK  = 32'h3000_0000;
  localparam logic [31:0] TAG_MASK  = 32'h00FF_0F00;
  localparam logic [31:0] ATTR_MASK = 32'h0000_007F;
  localparam logic [31:0] SRCH_MASK = 32'hFF00_0001;

  logic             wr_ok;
  logic [PID_W-1:0] tid_pick;
  logic [31:0]      sel_miss, tag_miss, attr_miss, srch_miss;

  assign wr_ok    = reg_en & reg_we & ~user_mode;
  assign priv_err = reg_en & user_mode;

  always_comb begin
    case (dflt_q[17:16])
      2'b00:   tid_pick = pid0;
      2'b01:   tid_pick = pid1;
      2'b10:   tid_pick = pid2;
      default: tid_pick = '0;
    endcase
  end

  always_comb begin
    sel_miss  = dflt_q & SEL_MASK;
    tag_miss  = '0;
    tag_miss[16 +: PID_W] = tid_pick;
    tag_miss[11:8] = dflt_q[11:8];
    attr_miss = dflt_q & ATTR_MASK;
    srch_miss = '0;
    srch_miss[31 -: PID_W] = pid0;
    srch_miss[0] = miss_as;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_q <= '0;
      sel_q  <= '0;
      tag_q  <= '0;
      attr_q <= '0;
      srch_q <= '0;
    end else begin
      if (wr_ok && reg_sel == 3'd0) dflt_q <= reg_wdata & DFLT_MASK;
      if (miss) begin
        sel_q  <= sel_miss;
        tag_q  <= tag_miss;
        attr_q <= attr_miss;
        srch_q <= srch_miss;
      end else if (wr_ok) begin
        case (reg_sel)
          3'd1: sel_q  <= reg_wdata & SEL_MASK;
          3'd2: tag_q  <= reg_wdata & TAG_MASK;
          3'd3: attr_q <= reg_wdata & ATTR_MASK;
          3'd4: srch_q <= reg_wdata & SRCH_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_en && !user_mode) begin
      case (reg_sel)
        3'd0: reg_rdata = dflt_q;
        3'd1: reg_rdata = sel_q;
        3'd2: reg_rdata = tag_q;
        3'd3: reg_rdata = attr_q;
        3'd4: reg_rdata = srch_q;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tlb_miss_loader_chk.sv
module tlb_miss_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_en,
  input logic        reg_we,
  input logic        user_mode,
  input logic [31:0] reg_rdata,
  input logic        priv_err,
  input logic [7:0]  pid0,
  input logic [7:0]  pid1,
  input logic [7:0]  pid2,
  input logic        miss,
  input logic        miss_as,
  input logic [31:0] dflt_q,
  input logic [31:0] sel_q,
  input logic [31:0] tag_q,
  input logic [31:0] attr_q,
  input logic [31:0] srch_q
);
  assert_dflt_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt_q & ~32'h3003_0F7F) == 32'h0);

  assert_tlbsel_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> sel_q[29:28] == $past(dflt_q[29:28]));

  assert_tid_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && dflt_q[17:16] == 2'b11) |=> tag_q[23:16] == 8'h00);

  assert_tid_pid1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && dflt_q[17:16] == 2'b01) |=> tag_q[23:16] == $past(pid1));

  assert_tid_pid2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && dflt_q[17:16] == 2'b10) |=> tag_q[23:16] == $past(pid2));

  assert_size_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> tag_q[11:8] == $past(dflt_q[11:8]));

  assert_attr_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> attr_q == ($past(dflt_q) & 32'h7F));

  assert_search_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> srch_q == {$past(pid0), 23'b0, $past(miss_as)});

  assert_user_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && user_mode) |-> (priv_err && reg_rdata == 32'h0));

  assert_user_nochange_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && user_mode && !miss) |=> ($stable(dflt_q) && $stable(sel_q) &&
      $stable(tag_q) && $stable(attr_q) && $stable(srch_q)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss && !(reg_en && reg_we)) |=> ($stable(dflt_q) && $stable(sel_q) &&
      $stable(tag_q) && $stable(attr_q) && $stable(srch_q)));
endmodule

bind tlb_miss_loader tlb_miss_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .user_mode(user_mode), .reg_rdata(reg_rdata), .priv_err(priv_err),
  .pid0(pid0), .pid1(pid1), .pid2(pid2), .miss(miss), .miss_as(miss_as),
  .dflt_q(dflt_q), .sel_q(sel_q), .tag_q(tag_q), .attr_q(attr_q),
  .srch_q(srch_q)
);

// File: tb/sim_tlb_miss_loader.sv
`timescale 1ns/1ps
module sim_tlb_miss_loader;
  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_we = 0, user_mode = 0, miss = 0, miss_as = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic priv_err;
  logic [7:0] pid0 = 0, pid1 = 0, pid2 = 0;
  logic [31:0] dflt_q, sel_q, tag_q, attr_q, srch_q;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  tlb_miss_loader u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_sel = idx; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_sel = idx;
    #1 v = reg_rdata;
    reg_en = 0;
  endtask

  task automatic do_miss(input logic [7:0] a, b, c, input logic as);
    @(negedge clk);
    pid0 = a; pid1 = b; pid2 = c; miss_as = as; miss = 1;
    @(negedge clk);
    miss = 0;
  endtask

  function automatic logic [7:0] pick(input logic [1:0] s, input logic [7:0] a, b, c);
    case (s)
      2'b00: return a;
      2'b01: return b;
      2'b10: return c;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    logic [7:0] a, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 dflt", dflt_q, 0); chk("R1 sel", sel_q, 0); chk("R1 tag", tag_q, 0);
    chk("R1 attr", attr_q, 0); chk("R1 srch", srch_q, 0); chk("R1 priv_err", {31'b0, priv_err}, 0);

    // R2: masked write/readback for every index
    for (int i = 0; i < 8; i++) begin
      wr(i[2:0], 32'hFFFF_FFFF);
      rd(i[2:0], v);
      case (i)
        0: chk("R2 dflt mask", v, 32'h3003_0F7F);
        1: chk("R2 sel mask", v, 32'h3000_0000);
        2: chk("R2 tag mask", v, 32'h00FF_0F00);
        3: chk("R2 attr mask", v, 32'h0000_007F);
        4: chk("R2 srch mask", v, 32'hFF00_0001);
        default: chk("R2 unmapped", v, 0);
      endcase
    end
    chk("R2 unmapped no side effect", sel_q ^ tag_q ^ attr_q, 32'h30FF_0F7F);

    // R8: user-mode write and read
    @(negedge clk);
    reg_en = 1; reg_we = 1; user_mode = 1; reg_sel = 4; reg_wdata = 32'h1200_0000;
    #1 chk("R8 priv_err", {31'b0, priv_err}, 1);
    chk("R8 rdata zero", reg_rdata, 0);
    @(negedge clk);
    reg_en = 0; reg_we = 0; user_mode = 0;
    chk("R8 srch unchanged", srch_q, 32'hFF00_0001);
    @(negedge clk);
    reg_en = 1; user_mode = 1; reg_sel = 0;
    #1 chk("R8 user read zero", reg_rdata, 0);
    reg_en = 0; user_mode = 0;

    // R10: hold across idle cycles
    repeat (4) @(negedge clk);
    chk("R10 hold dflt", dflt_q, 32'h3003_0F7F);
    chk("R10 hold tag", tag_q, 32'h00FF_0F00);

    // R3..R7: sweep table-select x id-select x size defaults
    for (int k = 0; k < 256; k++) begin
      d = ({28'b0, k[3:0]} << 28) & 32'h3000_0000;
      d = d | ({30'b0, k[1:0]} << 16) | ({28'b0, k[7:4]} << 8) | ((k * 37) & 32'h7F);
      d = d | ({30'b0, k[3:2]} << 28);
      a = 8'(k * 3 + 1); b = 8'(k * 5 + 2); c = 8'(k * 7 + 3);
      wr(3'd0, d);
      do_miss(a, b, c, k[0]);
      chk("R3 sel", sel_q, d & 32'h3000_0000);
      chk("R4 tid", {24'b0, tag_q[23:16]}, {24'b0, pick(d[17:16], a, b, c)});
      chk("R5 size", {28'b0, tag_q[11:8]}, {28'b0, d[11:8]});
      chk("R5 tag whole", tag_q & ~32'h00FF_0F00, 0);
      chk("R6 attr", attr_q, d & 32'h7F);
      chk("R7 srch", srch_q, {a, 23'b0, k[0]});
    end

    // R6: all attribute default patterns
    for (int k = 0; k < 128; k++) begin
      wr(3'd0, 32'h0003_0000 | k);
      do_miss(8'h11, 8'h22, 8'h33, 1'b0);
      chk("R6 attr sweep", attr_q, k);
      chk("R4 forced zero", {24'b0, tag_q[23:16]}, 0);
    end

    // R9: write and miss in same cycle
    wr(3'd0, 32'h1002_0A55);
    @(negedge clk);
    pid0 = 8'hA1; pid1 = 8'hB2; pid2 = 8'hC3; miss_as = 1; miss = 1;
    reg_en = 1; reg_we = 1; reg_sel = 2; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    miss = 0; reg_en = 0; reg_we = 0;
    chk("R9 tag miss wins", tag_q, 32'h00C3_0A00);
    @(negedge clk);
    miss = 1; pid0 = 8'h44; miss_as = 0;
    reg_en = 1; reg_we = 1; reg_sel = 0; reg_wdata = 32'h2000_0301;
    @(negedge clk);
    miss = 0; reg_en = 0; reg_we = 0;
    chk("R9 dflt written", dflt_q, 32'h2000_0301);
    chk("R9 miss used old dflt", attr_q, 32'h55);
    chk("R9 old tlbsel", sel_q, 32'h1000_0000);
    chk("R7 srch as0", srch_q, 32'h4400_0000);

    // R10: hold after sweep
    repeat (3) @(negedge clk);
    chk("R10 hold srch", srch_q, 32'h4400_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule